// File: doc/BRIEF.md
# LCD Scan Timing and Segment Generator

This block produces the row timing for a passive-matrix dot display. It counts oscillator ticks, supplied as a one-cycle enable, to form the line clock. It counts lines within a frame and flips the AC drive phase once per frame. For each line it presents the display memory row to read and the physical common to drive. It then latches the 100 segment bits of that row, shaped by the display controls.

The frame has two lengths. The long duty is 54 scrolled lines plus one icon line. The short duty is 33 scrolled lines plus one icon line. A scroll register chosen by software sets the row shown on the first common. That register is sampled only when a frame begins. The row counter wraps modulo 64. The icon row sits in the last line of every frame and is never scrolled. Software can reverse the common order. It can blank the display, force every segment on, or invert the pixels. A power-save state blanks the whole panel. In that state the oscillator either keeps running (standby) or is stopped (sleep).

Top module: `lcd_scan_timing`

## Requirements
- R1: `lineClk` is a one-cycle pulse issued once every 3 accepted oscillator ticks (`oscEn` high while the oscillator runs) when `dutyShort`=0, and once every 5 ticks when `dutyShort`=1.
- R2: A frame holds 55 lines (`dutyShort`=0) or 34 lines (`dutyShort`=1). `acPhase` inverts in the same cycle as the `lineClk` pulse that starts line 0 of a new frame, and at no other time.
- R3: Line 0 of every frame reads row `startLine`, sampled at that frame's first line clock. Each following scrolled line reads the previous row plus one, modulo 64. `rowAddr` changes only in a `lineClk` cycle.
- R4: The last line of each frame is the icon line. It always shows `rowAddr`=64 and `comIndex`=54, whatever `startLine` or `comReverse` is.
- R5: On scrolled line k, `comIndex` is k when `comReverse`=0. When `comReverse`=1 it is L-2-k, where L is the frame length.
- R6: `segOut` is captured at the clock edge that ends the `lineClk` cycle. It is built from `ramData` for the row shown in `rowAddr` and holds until the next line.
- R7: Display controls apply in this priority. `dispOn`=0 drives `segOut` to zero and `comEnable` low. Otherwise `allOn`=1 drives every segment to 1. Otherwise `invert`=1 outputs the complement of each RAM bit. `dispOn`=0 with `allOn`=0 does not enter power save.
- R8: `powerSave` rises the cycle after `dispOn`=0 with `allOn`=1. It stays set, even when `allOn` drops, until `dispOn`=1 with `allOn`=0 clears it. While it is set, `segOut` is zero and `comEnable` is low.
- R9: In power save with `staticInd`=1 (standby), `oscRun` stays high and line clocks continue. With `staticInd`=0 (sleep), `oscRun` is low and no `lineClk` occurs.
- R10: After reset, `lineClk`, `acPhase`, `rowAddr`, `comIndex`, `segOut` and `powerSave` are 0 and `oscRun` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | Oscillator tick enable |
| dutyShort | input | 1 | 0: 55-line frame, 1: 34-line frame |
| startLine | input | 6 | Scroll row shown on the first common |
| comReverse | input | 1 | Reverse common scan order |
| dispOn | input | 1 | Display enable |
| allOn | input | 1 | Force all segments on |
| invert | input | 1 | Invert pixel data |
| staticInd | input | 1 | Static indicator enable (standby instead of sleep) |
| ramData | input | 100 | Display memory row at `rowAddr` |
| lineClk | output | 1 | Line clock pulse |
| acPhase | output | 1 | Frame-alternating drive phase |
| rowAddr | output | 7 | Display memory row being scanned (64 = icon) |
| comIndex | output | 6 | Physical common being driven |
| comEnable | output | 1 | Commons are being driven |
| segOut | output | 100 | Segment on/off bits |
| powerSave | output | 1 | Power-save state |
| oscRun | output | 1 | Oscillator allowed to run |

## Verification
The properties assume that `ramData` follows `rowAddr` combinationally. This is how an asynchronous-read memory behaves. They also assume that `startLine` and `comReverse` change only between line clocks. The stimulus models the memory as a function of `rowAddr` evaluated continuously. It changes scroll, direction and display controls only after every expected line has been compared and the segment latch has settled. Duty and tick rate change only under reset, so the frame counter never sees a line index beyond the new frame length.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic             step;
    logic             wrap;
    logic             iconNext;
    logic [IDX_W-1:0] nextIdx;
    logic [IDX_W-1:0] lastScan;
    logic             latch;
  } scanStrobes_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import scan_pkg::*;
#(
  parameter int DIV_LONG    = 3,
  parameter int DIV_SHORT   = 5,
  parameter int LINES_LONG  = 55,
  parameter int LINES_SHORT = 34
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         oscEn,
  input  logic         dutyShort,
  input  logic         dispOn,
  input  logic         allOn,
  input  logic         staticInd,
  output scanStrobes_t strobes,
  output logic         lineClk,
  output logic         acPhase,
  output logic         powerSave,
  output logic         oscRun
);
  localparam int MAX_DIV = (DIV_LONG > DIV_SHORT) ? DIV_LONG : DIV_SHORT;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] divCnt, divLimit;
  logic [IDX_W-1:0] lineIdx, lineLast, nextIdx;
  logic             tick, step, frameEnd;

  always_comb begin
    divLimit = dutyShort ? DIV_W'(DIV_SHORT - 1) : DIV_W'(DIV_LONG - 1);
    lineLast = dutyShort ? IDX_W'(LINES_SHORT - 1) : IDX_W'(LINES_LONG - 1);
    oscRun   = !(powerSave && !staticInd);
    tick     = oscEn && oscRun;
    step     = tick && (divCnt >= divLimit);
    frameEnd = (lineIdx >= lineLast);
    nextIdx  = frameEnd ? '0 : lineIdx + 1'b1;
    strobes.step     = step;
    strobes.wrap     = step && frameEnd;
    strobes.iconNext = (nextIdx == lineLast);
    strobes.nextIdx  = nextIdx;
    strobes.lastScan = lineLast - 1'b1;
    strobes.latch    = lineClk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      lineIdx   <= '0;
      lineClk   <= 1'b0;
      acPhase   <= 1'b0;
      powerSave <= 1'b0;
    end else begin
      lineClk <= step;
      if (step)      divCnt <= '0;
      else if (tick) divCnt <= divCnt + 1'b1;
      if (step) begin
        lineIdx <= nextIdx;
        if (frameEnd) acPhase <= !acPhase;
      end
      if (!dispOn && allOn)      powerSave <= 1'b1;
      else if (dispOn && !allOn) powerSave <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_scan_datapath.sv
module lcd_scan_datapath
  import scan_pkg::*;
#(
  parameter int SEG_COUNT  = 100,
  parameter int LINES_LONG = 55,
  parameter int ROW_W      = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobes_t         strobes,
  input  logic [IDX_W-1:0]     startLine,
  input  logic                 comReverse,
  input  logic                 dispOn,
  input  logic                 allOn,
  input  logic                 invert,
  input  logic                 powerSave,
  input  logic [SEG_COUNT-1:0] ramData,
  output logic [ROW_W-1:0]     rowAddr,
  output logic [IDX_W-1:0]     comIndex,
  output logic                 comEnable,
  output logic [SEG_COUNT-1:0] segOut
);
  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(1 << IDX_W);
  localparam logic [IDX_W-1:0] COM_ICON = IDX_W'(LINES_LONG - 1);

  logic [IDX_W-1:0]     scanCnt;
  logic                 iconLine;
  logic [SEG_COUNT-1:0] segHeld, segNext;
  logic                 live;

  always_comb begin
    if (allOn)       segNext = '1;
    else if (invert) segNext = ~ramData;
    else             segNext = ramData;
    live      = dispOn && !powerSave;
    comEnable = live;
    segOut    = live ? segHeld : '0;
    rowAddr   = iconLine ? ICON_ROW : {1'b0, scanCnt};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanCnt  <= '0;
      iconLine <= 1'b0;
      comIndex <= '0;
      segHeld  <= '0;
    end else begin
      if (strobes.step) begin
        scanCnt  <= strobes.wrap ? startLine : scanCnt + 1'b1;
        iconLine <= strobes.iconNext;
        if (strobes.iconNext)
          comIndex <= COM_ICON;
        else
          comIndex <= comReverse ? strobes.lastScan - strobes.nextIdx : strobes.nextIdx;
      end
      if (strobes.latch) segHeld <= segNext;
    end
  end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import scan_pkg::*;
#(
  parameter int SEG_COUNT   = 100,
  parameter int DIV_LONG    = 3,
  parameter int DIV_SHORT   = 5,
  parameter int LINES_LONG  = 55,
  parameter int LINES_SHORT = 34
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oscEn,
  input  logic                 dutyShort,
  input  logic [5:0]           startLine,
  input  logic                 comReverse,
  input  logic                 dispOn,
  input  logic                 allOn,
  input  logic                 invert,
  input  logic                 staticInd,
  input  logic [SEG_COUNT-1:0] ramData,
  output logic                 lineClk,
  output logic                 acPhase,
  output logic [6:0]           rowAddr,
  output logic [5:0]           comIndex,
  output logic                 comEnable,
  output logic [SEG_COUNT-1:0] segOut,
  output logic                 powerSave,
  output logic                 oscRun
);
  scanStrobes_t strobes;

  lcd_scan_ctrl #(
    .DIV_LONG(DIV_LONG), .DIV_SHORT(DIV_SHORT),
    .LINES_LONG(LINES_LONG), .LINES_SHORT(LINES_SHORT)
  ) ctrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .dutyShort(dutyShort),
    .dispOn(dispOn), .allOn(allOn), .staticInd(staticInd),
    .strobes(strobes), .lineClk(lineClk), .acPhase(acPhase),
    .powerSave(powerSave), .oscRun(oscRun)
  );

  lcd_scan_datapath #(
    .SEG_COUNT(SEG_COUNT), .LINES_LONG(LINES_LONG), .ROW_W(7)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startLine(startLine),
    .comReverse(comReverse), .dispOn(dispOn), .allOn(allOn), .invert(invert),
    .powerSave(powerSave), .ramData(ramData), .rowAddr(rowAddr),
    .comIndex(comIndex), .comEnable(comEnable), .segOut(segOut)
  );
endmodule

// File: rtl/lcd_scan_timing_checker.sv
module lcd_scan_timing_checker #(
  parameter int SEG_COUNT  = 100,
  parameter int LINES_LONG = 55
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 oscEn,
  input logic                 dutyShort,
  input logic [5:0]           startLine,
  input logic                 comReverse,
  input logic                 dispOn,
  input logic                 allOn,
  input logic                 invert,
  input logic                 staticInd,
  input logic [SEG_COUNT-1:0] ramData,
  input logic                 lineClk,
  input logic                 acPhase,
  input logic [6:0]           rowAddr,
  input logic [5:0]           comIndex,
  input logic                 comEnable,
  input logic [SEG_COUNT-1:0] segOut,
  input logic                 powerSave,
  input logic                 oscRun
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    lineClk |=> !lineClk);

  assert_phase_on_clock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acPhase != $past(acPhase)) |-> lineClk);

  assert_frame_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acPhase != $past(acPhase)) |-> (rowAddr == {1'b0, $past(startLine)}));

  assert_row_on_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rowAddr != $past(rowAddr)) |-> lineClk);

  assert_icon_common_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rowAddr == 7'd64) |-> (comIndex == 6'(LINES_LONG - 1)));

  assert_blank_in_save_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |-> (segOut == '0 && !comEnable));

  assert_sleep_no_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    !oscRun |=> !lineClk);

  assert_awake_outside_save_R9: assert property (@(posedge clk) disable iff (!rstN)
    !powerSave |-> oscRun);
endmodule

bind lcd_scan_timing lcd_scan_timing_checker #(
  .SEG_COUNT(SEG_COUNT), .LINES_LONG(LINES_LONG)
) chk (.*);

// File: tb/lcd_scan_timing_test.sv
module lcd_scan_timing_test;
  typedef struct packed {
    logic [6:0]  row;
    logic [5:0]  com;
    logic        m;
    logic [99:0] seg;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oscEn = 1'b1;
  logic        dutyShort = 1'b0;
  logic [5:0]  startLine = 6'd10;
  logic        comReverse = 1'b0, dispOn = 1'b1, allOn = 1'b0, invert = 1'b0, staticInd = 1'b0;
  logic [99:0] ramData;
  logic        lineClk, acPhase, comEnable, powerSave, oscRun;
  logic [6:0]  rowAddr;
  logic [5:0]  comIndex;
  logic [99:0] segOut;

  int checks = 0, errors = 0;
  int pushCnt = 0, doneCnt = 0;
  bit monOn = 0, halfRate = 0, havePrev = 0, segPending = 0;
  int expGap = 0, sinceLast = 0;
  item_t q[$];
  item_t cur;
  int modIdx, modScan;
  logic modM;

  always #5 clk = ~clk;

  lcd_scan_timing uut (.*);

  function automatic logic [99:0] pattern(input logic [6:0] row);
    logic [99:0] p;
    for (int i = 0; i < 100; i++) p[i] = (((i * 5) + (int'(row) * 7)) % 11) < 4;
    return p;
  endfunction

  assign ramData = pattern(rowAddr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) oscEn <= halfRate ? ~oscEn : 1'b1;

  // monitor
  always @(negedge clk) begin
    if (monOn) begin
      sinceLast++;
      if (segPending) begin
        check(segOut == cur.seg, "R6", "segOut", 128'(segOut), 128'(cur.seg));
        segPending = 0;
        doneCnt++;
      end
      if (lineClk) begin
        if (havePrev && expGap != 0)
          check(sinceLast == expGap, "R1", "line clock period", 128'(sinceLast), 128'(expGap));
        havePrev = 1;
        sinceLast = 0;
        if (q.size() == 0) begin
          check(0, "R2", "unexpected line clock", 1, 0);
        end else begin
          cur = q.pop_front();
          check(rowAddr == cur.row, (cur.row == 7'd64) ? "R4" : "R3", "rowAddr",
                128'(rowAddr), 128'(cur.row));
          check(comIndex == cur.com, (cur.row == 7'd64) ? "R4" : "R5", "comIndex",
                128'(comIndex), 128'(cur.com));
          check(acPhase == cur.m, "R2", "acPhase", 128'(acPhase), 128'(cur.m));
          segPending = 1;
        end
      end
    end
  end

  task automatic runLines(input int n);
    int last;
    item_t it;
    for (int k = 0; k < n; k++) begin
      last = dutyShort ? 33 : 54;
      if (modIdx == last) begin
        modIdx = 0; modScan = startLine; modM = ~modM;
      end else begin
        modIdx++; modScan = (modScan + 1) % 64;
      end
      if (modIdx == last) begin
        it.row = 7'd64; it.com = 6'd54;
      end else begin
        it.row = 7'(modScan);
        it.com = comReverse ? 6'(last - 1 - modIdx) : 6'(modIdx);
      end
      it.m = modM;
      if (!dispOn) it.seg = '0;           // R7 blanking first
      else if (allOn) it.seg = '1;        // R7 all-on over invert
      else if (invert) it.seg = ~pattern(it.row);
      else it.seg = pattern(it.row);
      q.push_back(it);
      pushCnt++;
    end
    while (doneCnt != pushCnt) @(negedge clk);
  endtask

  task automatic resetDut();
    monOn = 0; havePrev = 0; segPending = 0;
    q.delete(); pushCnt = 0; doneCnt = 0;
    modIdx = 0; modScan = 0; modM = 0;
    @(negedge clk) rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!lineClk && !acPhase && rowAddr == 0 && comIndex == 0, "R10", "timing reset",
          {lineClk, acPhase, rowAddr, comIndex}, 0);
    check(segOut == '0 && !powerSave && oscRun, "R10", "output reset",
          {segOut != '0, powerSave, oscRun}, 1);
    sinceLast = 0;
    monOn = 1;
  endtask

  initial begin
    int seen;
    resetDut();
    expGap = 3;
    runLines(60);
    runLines(60);
    invert = 1; runLines(20);
    allOn = 1; runLines(10);
    check(!powerSave, "R7", "all-on with display on keeps power save off", powerSave, 0);
    allOn = 0; invert = 0; comReverse = 1; runLines(60);
    startLine = 6'd5; runLines(60);
    dispOn = 0; runLines(5);
    check(!powerSave && !comEnable, "R7", "display off alone", {powerSave, comEnable}, 0);
    dispOn = 1; comReverse = 0;

    dutyShort = 1; halfRate = 1; startLine = 6'd60;
    resetDut();
    expGap = 10;
    runLines(80);
    comReverse = 1; runLines(40);

    monOn = 0;
    staticInd = 1; dispOn = 0; allOn = 1;
    repeat (3) @(negedge clk);
    check(powerSave && oscRun && segOut == '0 && !comEnable, "R8", "standby entry",
          {powerSave, oscRun, segOut != '0, comEnable}, 4'b1100);
    seen = 0;
    repeat (40) begin @(negedge clk); if (lineClk) seen++; end
    check(seen > 0, "R9", "standby keeps line clock", seen, 1);
    staticInd = 0;
    repeat (2) @(negedge clk);
    check(!oscRun, "R9", "sleep stops oscillator", oscRun, 0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (lineClk) seen++; end
    check(seen == 0, "R9", "sleep has no line clock", seen, 0);
    allOn = 0;
    repeat (3) @(negedge clk);
    check(powerSave && segOut == '0, "R8", "power save held", powerSave, 1);
    dispOn = 1;
    repeat (2) @(negedge clk);
    check(!powerSave && oscRun && comEnable, "R8", "power save exit",
          {powerSave, oscRun, comEnable}, 3'b011);
    seen = 0;
    repeat (20) begin @(negedge clk); if (lineClk) seen++; end
    check(seen > 0, "R9", "line clock resumes", seen, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule